// File: doc/BRIEF.md
# Split Instruction/Data Memory with Big-Endian Lane Access

This block is the local memory of a small 32-bit processor core. One storage array is reached through two ports. The fetch port is read-only and returns whole 32-bit instruction words. The data port has a read channel and a write channel. Each channel has its own enable, byte address and size code, so one read and one write can complete in the same clock.

Addresses are byte addresses. The word index is the address shifted right by two. Byte lanes are big-endian: offset 0 is the most significant byte of a word. Sub-word reads come back right-aligned and zero-extended. Sub-word writes change only the addressed lanes. When a read and a write meet on the same word in one cycle, the read returns the contents from before the write. Illegal accesses raise a one-cycle fault flag and leave storage untouched.

The block has no file preload. Synchronous reset instead writes a computed pattern into every word: word i holds `32'h49303033 ^ (i * 32'h01010101)`, truncated to 32 bits.

Top module: `split_mem`

## Requirements
- R1: Size code 00 is a byte access. A byte read returns the lane picked by address bits 1..0, where offset 0 is bits 31..24 of the word and offset 3 is bits 7..0. The byte is placed in d_rdata[7:0] and the upper bits are zero.
- R2: Size code 01 is a halfword access. A halfword read at offset 0 returns bits 31..16 of the word and at offset 2 returns bits 15..0, zero-extended.
- R3: Size code 10 is a word access. A word read returns the full word stored at address bits AW-1..2.
- R4: A write takes its data from the low bits of wr_data: byte from 7..0, halfword from 15..0, word from 31..0. It changes only the addressed lanes and leaves the rest of the word unchanged.
- R5: A data read and a data write enabled in the same cycle on different words both complete in that cycle.
- R6: When a read and a write hit the same word in the same cycle, d_rdata shows the old contents. A read in the next cycle sees the new value.
- R7: d_ready is high in the cycle after any cycle with rd_en or wr_en high, and low otherwise.
- R8: The fetch port returns the full 32-bit word at if_addr on if_rdata one clock after if_en. It works independently of the data channels.
- R9: fault is high for exactly the cycle after an enabled access that is illegal. An access is illegal if its word index is at or above DEPTH, its size code is 11, a halfword access has address bit 0 set, or a word or fetch access has address bits 1..0 nonzero. A faulting read loads zero into its data register. A faulting write leaves storage unchanged.
- R10: A synchronous active-high reset clears if_rdata, d_rdata, d_ready and fault, and loads every word with the pattern given above.
- R11: if_rdata holds its value in cycles without if_en, and d_rdata holds its value in cycles without rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_en | input | 1 | Fetch request |
| if_addr | input | AW | Fetch byte address |
| if_rdata | output | 32 | Fetched word |
| rd_en | input | 1 | Data read request |
| rd_addr | input | AW | Data read byte address |
| rd_size | input | 2 | Read size code |
| d_rdata | output | 32 | Data read result, zero-extended |
| wr_en | input | 1 | Data write request |
| wr_addr | input | AW | Data write byte address |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data, right-aligned |
| d_ready | output | 1 | Access acknowledge |
| fault | output | 1 | Illegal access flag |

## Verification
Directed byte reads at all four offsets of one known word tell big-endian steering apart from little-endian steering. They also show whether the upper bits are zero. Byte and halfword writes followed by full-word reads show whether untouched lanes survive. A read and a write on the same word in one cycle tell read-old behaviour apart from write-through. The same pair on different words shows that both channels complete together. Misaligned, oversize-code and out-of-range accesses check the fault pulse, the zeroed read result and the unchanged storage. Seeded random mixes of all three channels are compared against a word model kept in the bench, which catches errors in the lane masks and in the index.

// File: rtl/split_mem_pkg.sv
package split_mem_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_e;

   // Reset-time contents of word i
   function automatic logic [31:0] init_word(input int unsigned i);
      logic [31:0] prod;
      prod = 32'(i) * 32'h0101_0101;
      return 32'h4930_3033 ^ prod;
   endfunction

endpackage

// File: rtl/smem_addr_chk.sv
// Decodes a byte address into a word index and flags illegal accesses.
module smem_addr_chk #(
   parameter int AW       = 32,
   parameter int DEPTH    = 256,
   parameter bit FORCE_WD = 1'b0,
   localparam int IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic [AW-1:0] addr,
   input  logic [1:0]    size,
   output logic [IW-1:0] idx,
   output logic          bad
);
   import split_mem_pkg::*;

   logic [AW-3:0] widx;
   logic          oob;
   logic          misal;

   assign widx = addr[AW-1:2];
   assign idx  = widx[IW-1:0];
   assign oob  = (widx >= (AW-2)'(DEPTH));

   generate
      if (FORCE_WD) begin : g_word_only
         assign misal = (addr[1:0] != 2'b00);
      end else begin : g_sized
         always_comb begin
            case (acc_size_e'(size))
               SZ_BYTE: misal = 1'b0;
               SZ_HALF: misal = addr[0];
               SZ_WORD: misal = (addr[1:0] != 2'b00);
               default: misal = 1'b1;
            endcase
         end
      end
   endgenerate

   assign bad = oob | misal;
endmodule

// File: rtl/smem_rd_lane.sv
// Big-endian lane extraction with zero extension.
module smem_rd_lane (
   input  logic [31:0] word,
   input  logic [1:0]  offs,
   input  logic [1:0]  size,
   output logic [31:0] value
);
   import split_mem_pkg::*;

   logic [7:0]  bsel;
   logic [15:0] hsel;

   always_comb begin
      case (offs)
         2'd0:    bsel = word[31:24];
         2'd1:    bsel = word[23:16];
         2'd2:    bsel = word[15:8];
         default: bsel = word[7:0];
      endcase
      hsel = offs[1] ? word[15:0] : word[31:16];
      case (acc_size_e'(size))
         SZ_BYTE: value = {24'd0, bsel};
         SZ_HALF: value = {16'd0, hsel};
         default: value = word;
      endcase
   end
endmodule

// File: rtl/smem_wr_lane.sv
// Merges right-aligned write data into the addressed big-endian lanes.
module smem_wr_lane #(
   localparam int LANES = 4
) (
   input  logic [31:0] old_word,
   input  logic [31:0] wdata,
   input  logic [1:0]  offs,
   input  logic [1:0]  size,
   output logic [31:0] new_word
);
   import split_mem_pkg::*;

   logic [31:0] placed;
   logic [LANES-1:0] hit;

   always_comb begin
      case (acc_size_e'(size))
         SZ_BYTE: placed = {4{wdata[7:0]}};
         SZ_HALF: placed = {2{wdata[15:0]}};
         default: placed = wdata;
      endcase
   end

   // Lane k holds bits 31-8k .. 24-8k, i.e. offset k is big-endian.
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      always_comb begin
         case (acc_size_e'(size))
            SZ_BYTE: hit[k] = (offs == 2'(k));
            SZ_HALF: hit[k] = (offs[1] == (k >= 2));
            default: hit[k] = 1'b1;
         endcase
      end
      assign new_word[31-8*k -: 8] = hit[k] ? placed[31-8*k -: 8]
                                            : old_word[31-8*k -: 8];
   end
endmodule

// File: rtl/split_mem.sv
module split_mem #(
   parameter int AW    = 32,
   parameter int DEPTH = 256,
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          if_en,
   input  logic [AW-1:0] if_addr,
   output logic [31:0]   if_rdata,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   input  logic [1:0]    rd_size,
   output logic [31:0]   d_rdata,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [1:0]    wr_size,
   input  logic [31:0]   wr_data,
   output logic          d_ready,
   output logic          fault
);
   import split_mem_pkg::*;

   initial begin
      if (DEPTH < 2) $error("split_mem: DEPTH must be at least 2");
      if (AW < IW + 3) $error("split_mem: AW too narrow for DEPTH");
   end

   logic [31:0]   mem [DEPTH];
   logic [IW-1:0] if_idx, rd_idx, wr_idx;
   logic          if_bad, rd_bad, wr_bad;
   logic [31:0]   rd_val, wr_merged;

   smem_addr_chk #(.AW(AW), .DEPTH(DEPTH), .FORCE_WD(1'b1)) u_if_chk (
      .addr(if_addr), .size(2'b10), .idx(if_idx), .bad(if_bad));
   smem_addr_chk #(.AW(AW), .DEPTH(DEPTH), .FORCE_WD(1'b0)) u_rd_chk (
      .addr(rd_addr), .size(rd_size), .idx(rd_idx), .bad(rd_bad));
   smem_addr_chk #(.AW(AW), .DEPTH(DEPTH), .FORCE_WD(1'b0)) u_wr_chk (
      .addr(wr_addr), .size(wr_size), .idx(wr_idx), .bad(wr_bad));

   smem_rd_lane u_rd_lane (
      .word(mem[rd_idx]), .offs(rd_addr[1:0]), .size(rd_size), .value(rd_val));
   smem_wr_lane u_wr_lane (
      .old_word(mem[wr_idx]), .wdata(wr_data), .offs(wr_addr[1:0]),
      .size(wr_size), .new_word(wr_merged));

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= init_word(i);
         if_rdata <= '0;
         d_rdata  <= '0;
         d_ready  <= 1'b0;
         fault    <= 1'b0;
      end else begin
         if (if_en) if_rdata <= if_bad ? 32'd0 : mem[if_idx];
         if (rd_en) d_rdata  <= rd_bad ? 32'd0 : rd_val;   // old contents on collision
         if (wr_en && !wr_bad) mem[wr_idx] <= wr_merged;
         d_ready <= rd_en | wr_en;
         fault   <= (if_en & if_bad) | (rd_en & rd_bad) | (wr_en & wr_bad);
      end
   end

   assert_ready_ack_R7: assert property (@(posedge clk) disable iff (rst)
      (rd_en || wr_en) |=> d_ready);
   assert_ready_idle_R7: assert property (@(posedge clk) disable iff (rst)
      !(rd_en || wr_en) |=> !d_ready);
   assert_byte_zext_R1: assert property (@(posedge clk) disable iff (rst)
      (rd_en && rd_size == SZ_BYTE) |=> (d_rdata[31:8] == 24'd0));
   assert_dhold_R11: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(d_rdata));
   assert_ihold_R11: assert property (@(posedge clk) disable iff (rst)
      !if_en |=> $stable(if_rdata));
   assert_bad_read_R9: assert property (@(posedge clk) disable iff (rst)
      (rd_en && rd_bad) |=> (fault && d_rdata == 32'd0));
   assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      !(rd_en || wr_en || if_en) |=> !fault);
endmodule

// File: tb/test_split_mem.sv
module test_split_mem;
   localparam int AW    = 32;
   localparam int DEPTH = 256;

   logic          clk = 1'b0;
   logic          rst;
   logic          if_en, rd_en, wr_en;
   logic [AW-1:0] if_addr, rd_addr, wr_addr;
   logic [1:0]    rd_size, wr_size;
   logic [31:0]   wr_data;
   logic [31:0]   if_rdata, d_rdata;
   logic          d_ready, fault;

   int n_checks = 0;
   int n_fail   = 0;

   logic [31:0] model [DEPTH];
   logic [31:0] e_if, e_rd;
   logic        e_rdy, e_flt;

   always #5 clk = ~clk;

   split_mem #(.AW(AW), .DEPTH(DEPTH)) i_split_mem (
      .clk(clk), .rst(rst),
      .if_en(if_en), .if_addr(if_addr), .if_rdata(if_rdata),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_size(rd_size), .d_rdata(d_rdata),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
      .d_ready(d_ready), .fault(fault));

   function automatic logic [31:0] pattern(input int i);
      return 32'h4930_3033 ^ (32'(i) * 32'h0101_0101);
   endfunction

   function automatic bit illegal(input logic [31:0] a, input logic [1:0] s);
      if ((a >> 2) >= DEPTH) return 1'b1;
      if (s == 2'b11) return 1'b1;
      if (s == 2'b01 && a[0]) return 1'b1;
      if (s == 2'b10 && a[1:0] != 2'b00) return 1'b1;
      return 1'b0;
   endfunction

   // Shift-based big-endian extraction
   function automatic logic [31:0] pick(input logic [31:0] w, input logic [1:0] o,
                                        input logic [1:0] s);
      if (s == 2'b00) return (w >> (8 * (3 - o))) & 32'hFF;
      if (s == 2'b01) return (w >> (16 * (1 - o[1]))) & 32'hFFFF;
      return w;
   endfunction

   function automatic logic [31:0] put(input logic [31:0] w, input logic [1:0] o,
                                       input logic [1:0] s, input logic [31:0] d);
      logic [31:0] m;
      int sh;
      if (s == 2'b00) begin sh = 8 * (3 - o); m = 32'hFF << sh; end
      else if (s == 2'b01) begin sh = 16 * (1 - o[1]); m = 32'hFFFF << sh; end
      else begin sh = 0; m = 32'hFFFF_FFFF; end
      return (w & ~m) | ((d << sh) & m);
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // One clock: apply inputs at negedge, predict, check at next negedge.
   task automatic cycle(input string tag,
                        input logic ie, input logic [31:0] ia,
                        input logic re, input logic [31:0] ra, input logic [1:0] rs,
                        input logic we, input logic [31:0] wa, input logic [1:0] ws,
                        input logic [31:0] wd);
      if_en = ie; if_addr = ia;
      rd_en = re; rd_addr = ra; rd_size = rs;
      wr_en = we; wr_addr = wa; wr_size = ws; wr_data = wd;
      if (ie) e_if = illegal(ia, 2'b10) ? 32'd0 : model[ia[9:2]];
      if (re) e_rd = illegal(ra, rs) ? 32'd0 : pick(model[ra[9:2]], ra[1:0], rs);
      e_rdy = re | we;
      e_flt = (ie && illegal(ia, 2'b10)) || (re && illegal(ra, rs)) ||
              (we && illegal(wa, ws));
      if (we && !illegal(wa, ws))
         model[wa[9:2]] = put(model[wa[9:2]], wa[1:0], ws, wd);
      @(posedge clk);
      @(negedge clk);
      chk(tag, "if_rdata", if_rdata, e_if);
      chk(tag, "d_rdata", d_rdata, e_rd);
      chk(tag, "d_ready", 32'(d_ready), 32'(e_rdy));
      chk(tag, "fault", 32'(fault), 32'(e_flt));
   endtask

   task automatic idle(input string tag);
      cycle(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic rd(input string tag, input logic [31:0] a, input logic [1:0] s);
      cycle(tag, 0, 0, 1, a, s, 0, 0, 0, 0);
   endtask

   task automatic wr(input string tag, input logic [31:0] a, input logic [1:0] s,
                     input logic [31:0] d);
      cycle(tag, 0, 0, 0, 0, 0, 1, a, s, d);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h5EED);
      for (int i = 0; i < DEPTH; i++) model[i] = pattern(i);
      e_if = 0; e_rd = 0; e_rdy = 0; e_flt = 0;
      rst = 1;
      if_en = 0; if_addr = 0; rd_en = 0; rd_addr = 0; rd_size = 0;
      wr_en = 0; wr_addr = 0; wr_size = 0; wr_data = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 0;
      // R10: reset state of outputs and contents
      idle("R10");
      cycle("R10 R8", 1, 32'h0, 0, 0, 0, 0, 0, 0, 0);
      cycle("R10 R8", 1, 32'h3FC, 0, 0, 0, 0, 0, 0, 0);
      // R1: big-endian byte lanes of word 3
      for (int o = 0; o < 4; o++) rd("R1", 32'h0C + o, 2'b00);
      // R2 / R3
      rd("R2", 32'h10, 2'b01);
      rd("R2", 32'h12, 2'b01);
      rd("R3", 32'h14, 2'b10);
      // R11: hold without enables
      idle("R11");
      idle("R11");
      // R4: byte and halfword writes, then read back the whole word
      wr("R4", 32'h11, 2'b00, 32'hFFFF_FF34);
      rd("R4", 32'h10, 2'b10);
      wr("R4", 32'h22, 2'b01, 32'hABCD_1234);
      rd("R4", 32'h20, 2'b10);
      wr("R4", 32'h24, 2'b10, 32'hDEAD_BEEF);
      rd("R4", 32'h24, 2'b10);
      // R5: read and write on different words
      cycle("R5", 0, 0, 1, 32'h0C, 2'b00, 1, 32'h15, 2'b00, 32'h35);
      rd("R5", 32'h14, 2'b10);
      // R6: same word collision
      cycle("R6", 0, 0, 1, 32'h1D, 2'b00, 1, 32'h1D, 2'b00, 32'h37);
      rd("R6", 32'h1D, 2'b00);
      // R8: fetch alongside data traffic
      cycle("R8", 1, 32'h24, 1, 32'h0F, 2'b00, 1, 32'h24, 2'b10, 32'h0BAD_F00D);
      cycle("R8", 1, 32'h24, 0, 0, 0, 0, 0, 0, 0);
      // R9: illegal accesses
      rd("R9", 32'h11, 2'b01);
      rd("R9", 32'h12, 2'b10);
      rd("R9", 32'h10, 2'b11);
      rd("R9", DEPTH * 4, 2'b00);
      wr("R9", 32'h31, 2'b10, 32'h1111_1111);
      rd("R9", 32'h30, 2'b10);
      cycle("R9", 1, 32'h2, 0, 0, 0, 0, 0, 0, 0);
      idle("R9 R7");
      // Random mix (R1..R9)
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] a1, a2, a3;
         logic [1:0]  s1, s2;
         a1 = ($urandom_range(0, DEPTH + 3) << 2) | $urandom_range(0, 3);
         a2 = ($urandom_range(0, DEPTH + 3) << 2) | $urandom_range(0, 3);
         a3 = ($urandom_range(0, DEPTH + 3) << 2) |
              (($urandom_range(0, 7) == 0) ? 2'd2 : 2'd0);
         s1 = ($urandom_range(0, 15) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
         s2 = ($urandom_range(0, 15) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
         if (s1 == 2'b01) a1[0] = ($urandom_range(0, 7) == 0);
         if (s1 == 2'b10) a1[1:0] = ($urandom_range(0, 7) == 0) ? 2'd1 : 2'd0;
         if (s2 == 2'b01) a2[0] = ($urandom_range(0, 7) == 0);
         if (s2 == 2'b10) a2[1:0] = ($urandom_range(0, 7) == 0) ? 2'd3 : 2'd0;
         if ($urandom_range(0, 9) == 0) a2 = a1;
         cycle("R5 random", 1'($urandom_range(0, 1)), a3,
               1'($urandom_range(0, 1)), a1, s1,
               1'($urandom_range(0, 1)), a2, s2, $urandom);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule